// File: doc/BRIEF.md
# Sync Pulse to Square-Wave Reference Generator

This block turns a narrow periodic sync pulse into a square wave with the same period and a duty cycle close to 50%. The result can serve as the reference input of a frequency-multiplying loop. The block runs on a 10 MHz local tick. With the default values, a pulse arrives every 4096 ticks (409.6 µs), and each pulse is about one tick wide.

The pulse goes through a two-stage synchronizer and a rising-edge detector. Each detected edge restarts a phase counter, and the output is high for the first half of each counted period. The rising edge of the output is therefore placed a fixed number of ticks after the pulse arrives, and the output re-aligns on every pulse. If pulses stop, the output keeps running at the nominal period. A flag reports that no pulse has been seen for one period plus a grace window.

Top module: `sync_pulse_clock_gen`

## Requirements
- R1: While reset is asserted and directly after it, `clk_out` and `pulse_missing` are both low.
- R2: `pulse_in` may be sampled high at clock edge k after being low at edge k-1. In that case, `clk_out` is high right after edge k+2 and low right after edges k and k+1, provided it was low before.
- R3: After an alignment, `clk_out` stays high for PERIOD/2 ticks and then stays low for the rest of the PERIOD ticks.
- R4: A pulse detected during the low phase restarts the period at once, so the output rises early.
- R5: A pulse detected during the high phase restarts the high phase. The output does not drop, and it stays high for a further PERIOD/2 ticks.
- R6: When pulses stop, `clk_out` keeps toggling with period PERIOD, counted from the last alignment.
- R7: `pulse_missing` rises once PERIOD+GRACE clock edges have passed since the last alignment, or since reset if there was none. It falls on the alignment edge of the next pulse.
- R8: Until the first pulse is detected after reset, `clk_out` stays low.
- R9: An input held high for many ticks produces a single alignment, at its rising edge only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 1 | Asynchronous periodic sync pulse |
| clk_out | output | 1 | Regenerated square-wave reference |
| pulse_missing | output | 1 | High when no pulse has been seen within PERIOD+GRACE ticks |

## Verification
The assertions assume that `pulse_in` returns low between pulses for at least one tick. Without that, edge detection would merge two pulses into one alignment. The stimulus keeps every generated pulse one tick wide, separated by at least two low ticks. The only exception is one deliberate long-high case, which tests that a held input aligns only once. Random pulse spacings range from a few ticks to beyond the missing-pulse limit, so early pulses, pulses in the high phase, on-time pulses and dropouts all occur. These cases are mixed with directed cases for latency, reset and recovery.

// File: rtl/sync_pulse_clock_gen.sv
module sync_pulse_clock_gen #(
  parameter int PERIOD      = 4096,
  parameter int GRACE       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic clk_out,
  output logic pulse_missing
);
  localparam int HALF  = PERIOD / 2;
  localparam int LIMIT = PERIOD + GRACE;
  localparam int PW    = $clog2(PERIOD);
  localparam int GW    = $clog2(LIMIT + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_d;
  logic [PW-1:0]          phase;
  logic [GW-1:0]          gap;
  logic                   locked;

  wire align = sync_q[SYNC_STAGES-1] & ~sync_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      sync_d <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pulse_in};
      sync_d <= sync_q[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= '0;
      locked <= 1'b0;
    end else if (align) begin
      phase  <= '0;
      locked <= 1'b1;
    end else if (phase == PW'(PERIOD - 1)) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                gap <= '0;
    else if (align)            gap <= '0;
    else if (gap != GW'(LIMIT)) gap <= gap + 1'b1;
  end

  assign clk_out       = locked & (phase < PW'(HALF));
  assign pulse_missing = (gap == GW'(LIMIT));

  assert_rise_after_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    align |=> clk_out);
  assert_no_drop_on_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_out) |-> !$past(align));
  assert_flag_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    align |=> !pulse_missing);
  assert_single_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    align |=> !align);
  assert_stays_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
endmodule

// File: tb/sync_pulse_clock_gen_tb.sv
module sync_pulse_clock_gen_tb;
  localparam int P     = 512;
  localparam int G     = 16;
  localparam int HALF  = P / 2;
  localparam int LIMIT = P + G;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_in = 1'b0;
  logic clk_out, pulse_missing;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [3:0] hist = '0;
  int  ref_ph = 0, ref_gap = 0;
  bit  ref_locked = 0;

  always #5 clk = ~clk;

  sync_pulse_clock_gen #(.PERIOD(P), .GRACE(G), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in),
    .clk_out(clk_out), .pulse_missing(pulse_missing));

  function automatic bit exp_out();
    return ref_locked && (ref_ph < HALF);
  endfunction

  function automatic bit exp_miss();
    return ref_gap == LIMIT;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b time=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input bit p, input string req);
    pulse_in = p;
    @(posedge clk);
    hist = {hist[2:0], p};
    if (hist[2] && !hist[3]) begin
      ref_ph = 0; ref_gap = 0; ref_locked = 1;
    end else begin
      ref_ph  = (ref_ph == P - 1) ? 0 : ref_ph + 1;
      ref_gap = (ref_gap == LIMIT) ? LIMIT : ref_gap + 1;
    end
    @(negedge clk);
    check(req, clk_out, exp_out());
    check(req, pulse_missing, exp_miss());
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) tick(1'b0, req);
  endtask

  task automatic pulse(input string req);
    tick(1'b1, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", clk_out, 1'b0);
    check("R1", pulse_missing, 1'b0);
    rst_n = 1'b1;

    idle(20, "R8");
    check("R8", clk_out, 1'b0);

    pulse("R2");
    check("R2", clk_out, 1'b0);
    tick(1'b0, "R2");
    check("R2", clk_out, 1'b0);
    tick(1'b0, "R2");
    check("R2", clk_out, 1'b1);

    for (int k = 0; k < 5; k++) begin
      idle(P - 1 - (k == 0 ? 2 : 0), "R3");
      pulse("R3");
    end
    idle(HALF + 10, "R3");
    check("R3", clk_out, 1'b0);

    pulse("R4");
    idle(2, "R4");
    check("R4", clk_out, 1'b1);

    idle(100, "R5");
    pulse("R5");
    idle(HALF - 40, "R5");
    check("R5", clk_out, 1'b1);

    idle(60, "R9");
    for (int i = 0; i < 50; i++) tick(1'b1, "R9");
    idle(HALF + 10, "R9");
    check("R9", clk_out, 1'b0);

    idle(2 * P, "R6");
    check("R7", pulse_missing, 1'b1);
    pulse("R7");
    idle(2, "R7");
    check("R7", pulse_missing, 1'b0);

    void'($urandom(32'h5eed));
    for (int n = 0; n < 40; n++) begin
      int gapn = $urandom_range(3, P + 40);
      idle(gapn, "R4");
      pulse("R4");
    end
    idle(P + G + 5, "R7");
    check("R7", pulse_missing, 1'b1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(1_900_000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule